// File: doc/BRIEF.md
# Float-to-Integer Converter

This unit turns an IEEE-754 binary32 or binary64 operand into a 32-bit or 64-bit integer, signed or unsigned. One control input picks the source format and one picks the destination width. A signedness input and a rounding input complete the set. With the rounding input low, the value rounds to the nearest integer and ties go to the even integer. With it high, the value is chopped toward zero. The result and a status update word come out of a single output register. Each conversion takes one clock, and a new operand may be presented every cycle.

The special cases follow a fixed priority. A NaN of either sign gives an all-ones pattern at the destination width. For a signed destination that pattern is -1. A negative input aimed at an unsigned destination gives 0 and raises invalid, however small the input is. This sign test is made before any rounding. Finite or infinite values outside the destination range saturate. Signed and unsigned zero both convert quietly to 0. The status word reports invalid and inexact at fixed bit positions for a neighbouring status register to merge.

Top module: `fp_to_int_cvt`

## Requirements
- R1: While `rst_n` is low, `int_out` and `status_set` read zero, and reset takes effect without waiting for a clock edge.
- R2: The outputs for the inputs sampled at one rising clock edge appear just after that edge and hold until the next edge.
- R3: With `src_double` = 0 the operand is binary32 in `op_bits[31:0]`, and `op_bits[63:32]` has no effect. With `src_double` = 1 all 64 bits are binary64.
- R4: With `chop_mode` = 0, a value with a nonzero fraction rounds to the nearest integer, and exact halves go to the even neighbour (2.5 gives 2, 3.5 gives 4, 0.5 gives 0, -2.5 gives -2).
- R5: With `chop_mode` = 1, the fraction is discarded toward zero (2.5 gives 2, -3.5 gives -3).
- R6: With `dst_signed` = 0, any negative input that is not zero gives 0 and sets invalid. This covers tiny values, -infinity, both rounding modes and both widths, and it applies even when rounding would have produced 0.
- R7: A NaN input gives all ones at the destination width and sets invalid. For a signed destination this is -1.
- R8: A value outside the destination range saturates and sets invalid. This includes infinities and values that overflow only after rounding up. Unsigned results clamp to all ones. Signed results clamp to 2^(W-1)-1 or -2^(W-1). -2^(W-1) itself converts exactly, with no flag.
- R9: Inexact is set when nonzero fraction bits were dropped or rounded, unless invalid is set for the same conversion. The two flags are never set together.
- R10: +0 and -0 convert to 0 with no flag, for every destination.
- R11: With `dst_wide` = 0, `int_out[63:32]` is zero, and the 32-bit result sits in `int_out[31:0]` in two's complement.
- R12: `status_set` carries invalid in bit 1 and inexact in bit 5. Bits 0 and 4:2 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_bits | input | 64 | Floating-point operand bits |
| src_double | input | 1 | 1: binary64 operand, 0: binary32 in low half |
| dst_wide | input | 1 | 1: 64-bit destination, 0: 32-bit destination |
| dst_signed | input | 1 | 1: signed destination, 0: unsigned |
| chop_mode | input | 1 | 1: truncate toward zero, 0: nearest even |
| int_out | output | 64 | Registered integer result |
| status_set | output | 6 | Registered status update, bit 1 invalid, bit 5 inexact |

## Verification
The assertions assume that every input holds a known level across each rising edge. They also assume that the classification the unpacker makes in one cycle is the one that the output register captures at that edge. The assertions therefore tie a classification seen before an edge to the registered result after it. To keep within these assumptions, the stimulus changes every input only at falling edges and never leaves a control undriven. Any bit pattern is a legal operand, so the operands cover NaNs, infinities, subnormals, both zeros and values next to every saturation limit.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  localparam int SP_FRAC  = 23;
  localparam int DP_FRAC  = 52;
  localparam int MANT_W   = DP_FRAC + 1;
  localparam int EXP_W    = 13;
  localparam int ST_W     = 6;
  localparam int ST_INVALID = 1;
  localparam int ST_INEXACT = 5;

  typedef struct packed {
    logic                    sign;
    logic                    nan;
    logic                    inf;
    logic                    zero;
    logic signed [EXP_W-1:0] exp;   // unbiased exponent of mant's top bit
    logic [MANT_W-1:0]       mant;  // hidden bit at MSB, binary64 alignment
  } f2i_num_t;

  function automatic f2i_num_t split_single(input logic [31:0] w);
    f2i_num_t n;
    logic [7:0] e;
    logic [SP_FRAC-1:0] f;
    e = w[30:23];
    f = w[SP_FRAC-1:0];
    n.sign = w[31];
    n.nan  = (e == 8'hFF) && (f != '0);
    n.inf  = (e == 8'hFF) && (f == '0);
    n.zero = (e == 8'h00) && (f == '0);
    n.exp  = (e == 8'h00) ? -13'sd126 : ($signed({5'b0, e}) - 13'sd127);
    n.mant = {(e != 8'h00), f, {(DP_FRAC - SP_FRAC){1'b0}}};
    return n;
  endfunction

  function automatic f2i_num_t split_double(input logic [63:0] w);
    f2i_num_t n;
    logic [10:0] e;
    logic [DP_FRAC-1:0] f;
    e = w[62:52];
    f = w[DP_FRAC-1:0];
    n.sign = w[63];
    n.nan  = (e == 11'h7FF) && (f != '0);
    n.inf  = (e == 11'h7FF) && (f == '0);
    n.zero = (e == 11'h000) && (f == '0);
    n.exp  = (e == 11'h000) ? -13'sd1022 : ($signed({2'b0, e}) - 13'sd1023);
    n.mant = {(e != 11'h000), f};
    return n;
  endfunction

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
  import f2i_pkg::*;
(
  input  logic [63:0] op_bits,
  input  logic        src_double,
  output f2i_num_t    num
);

  always_comb begin
    if (src_double) num = split_double(op_bits);
    else            num = split_single(op_bits[31:0]);
  end

endmodule

// File: rtl/f2i_align.sv
module f2i_align
  import f2i_pkg::*;
#(
  parameter int OUT_W = 64
) (
  input  logic signed [EXP_W-1:0] exp_in,
  input  logic [MANT_W-1:0]       mant_in,
  input  logic                    inf_in,
  input  logic                    chop,
  output logic [OUT_W:0]          mag,
  output logic                    huge,
  output logic                    lost
);

  localparam int FRAC_W = OUT_W;
  localparam int TW     = OUT_W + FRAC_W;
  localparam int PAD_W  = TW - FRAC_W - MANT_W;
  localparam logic signed [EXP_W-1:0] E_TOP  = EXP_W'(OUT_W - 1);
  localparam logic signed [EXP_W-1:0] E_UNIT = EXP_W'(MANT_W - 1);
  localparam logic signed [EXP_W-1:0] E_LOW  = -EXP_W'(FRAC_W);

  logic [TW-1:0]    base;
  logic [TW-1:0]    shifted;
  logic [OUT_W-1:0] ipart;
  logic             rbit;
  logic             sticky;
  logic             tiny;
  logic             rnd_up;

  assign base = {{PAD_W{1'b0}}, mant_in, {FRAC_W{1'b0}}};

  always_comb begin
    huge    = inf_in || (exp_in > E_TOP);
    tiny    = 1'b0;
    shifted = '0;
    if (huge) begin
      shifted = '0;
    end else if (exp_in >= E_UNIT) begin
      shifted = base << 7'(exp_in - E_UNIT);
    end else if (exp_in >= E_LOW) begin
      shifted = base >> 7'(E_UNIT - exp_in);
    end else begin
      tiny = |mant_in;
    end
  end

  assign ipart  = shifted[TW-1:FRAC_W];
  assign rbit   = shifted[FRAC_W-1];
  assign sticky = (|shifted[FRAC_W-2:0]) | tiny;
  assign rnd_up = !chop && rbit && (sticky || ipart[0]);
  assign mag    = {1'b0, ipart} + {{OUT_W{1'b0}}, rnd_up};
  assign lost   = rbit | sticky;

endmodule

// File: rtl/f2i_limit.sv
module f2i_limit #(
  parameter int OUT_W    = 64,
  parameter int NARROW_W = 32
) (
  input  logic             sign,
  input  logic             nan,
  input  logic             zero,
  input  logic             huge,
  input  logic [OUT_W:0]   mag,
  input  logic             lost,
  input  logic             wide,
  input  logic             signed_d,
  output logic [OUT_W-1:0] res,
  output logic             inv,
  output logic             inx,
  output logic             neg_reject,
  output logic             sat_hit
);

  localparam int GAP = OUT_W - NARROW_W;

  logic [OUT_W:0] umax;
  logic [OUT_W:0] spos;
  logic [OUT_W:0] sneg;
  logic [OUT_W-1:0] negmag;

  assign umax = wide ? {1'b0, {OUT_W{1'b1}}}
                     : {{(GAP + 1){1'b0}}, {NARROW_W{1'b1}}};
  assign spos = wide ? {2'b00, {(OUT_W - 1){1'b1}}}
                     : {{(GAP + 2){1'b0}}, {(NARROW_W - 1){1'b1}}};
  assign sneg = wide ? {2'b01, {(OUT_W - 1){1'b0}}}
                     : {{(GAP + 1){1'b0}}, 1'b1, {(NARROW_W - 1){1'b0}}};
  assign negmag = '0 - mag[OUT_W-1:0];

  always_comb begin
    res        = '0;
    inv        = 1'b0;
    neg_reject = 1'b0;
    sat_hit    = 1'b0;
    if (nan) begin
      res = umax[OUT_W-1:0];
      inv = 1'b1;
    end else if (zero) begin
      res = '0;
    end else if (!signed_d) begin
      if (sign) begin
        neg_reject = 1'b1;
        inv        = 1'b1;
      end else if (huge || (mag > umax)) begin
        sat_hit = 1'b1;
        inv     = 1'b1;
        res     = umax[OUT_W-1:0];
      end else begin
        res = mag[OUT_W-1:0];
      end
    end else if (!sign) begin
      if (huge || (mag > spos)) begin
        sat_hit = 1'b1;
        inv     = 1'b1;
        res     = spos[OUT_W-1:0];
      end else begin
        res = mag[OUT_W-1:0];
      end
    end else begin
      if (huge || (mag > sneg)) begin
        sat_hit = 1'b1;
        inv     = 1'b1;
        res     = sneg[OUT_W-1:0];
      end else begin
        res = negmag;
      end
    end
    if (!wide) res[OUT_W-1:NARROW_W] = '0;
  end

  assign inx = lost && !inv;

endmodule

// File: rtl/fp_to_int_cvt.sv
module fp_to_int_cvt
  import f2i_pkg::*;
#(
  parameter int OUT_W    = 64,
  parameter int NARROW_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      op_bits,
  input  logic             src_double,
  input  logic             dst_wide,
  input  logic             dst_signed,
  input  logic             chop_mode,
  output logic [OUT_W-1:0] int_out,
  output logic [ST_W-1:0]  status_set
);

  f2i_num_t         num;
  logic [OUT_W:0]   mag;
  logic             huge;
  logic             lost;
  logic [OUT_W-1:0] res_d;
  logic             inv_d;
  logic             inx_d;
  logic             neg_reject;
  logic             sat_hit;
  logic [ST_W-1:0]  status_d;

  f2i_unpack u_unpack (
    .op_bits    (op_bits),
    .src_double (src_double),
    .num        (num)
  );

  f2i_align #(.OUT_W(OUT_W)) u_align (
    .exp_in  (num.exp),
    .mant_in (num.mant),
    .inf_in  (num.inf),
    .chop    (chop_mode),
    .mag     (mag),
    .huge    (huge),
    .lost    (lost)
  );

  f2i_limit #(.OUT_W(OUT_W), .NARROW_W(NARROW_W)) u_limit (
    .sign       (num.sign),
    .nan        (num.nan),
    .zero       (num.zero),
    .huge       (huge),
    .mag        (mag),
    .lost       (lost),
    .wide       (dst_wide),
    .signed_d   (dst_signed),
    .res        (res_d),
    .inv        (inv_d),
    .inx        (inx_d),
    .neg_reject (neg_reject),
    .sat_hit    (sat_hit)
  );

  always_comb begin
    status_d             = '0;
    status_d[ST_INVALID] = inv_d;
    status_d[ST_INEXACT] = inx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_out    <= '0;
      status_set <= '0;
    end else begin
      int_out    <= res_d;
      status_set <= status_d;
    end
  end

  AST_UNSIGNED_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    neg_reject |=> (int_out == '0) && status_set[ST_INVALID]); // R6

  AST_NAN_ALLONES: assert property (@(posedge clk) disable iff (!rst_n)
    num.nan |=> status_set[ST_INVALID] &&
      (int_out == ($past(dst_wide) ? {OUT_W{1'b1}}
                                   : {{(OUT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}}))); // R7

  AST_SAT_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hit |=> status_set[ST_INVALID]); // R8

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    status_set[ST_INVALID] |-> !status_set[ST_INEXACT]); // R9

  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    num.zero |=> (int_out == '0) && (status_set == '0)); // R10

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_wide |=> (int_out[OUT_W-1:NARROW_W] == '0)); // R11

endmodule

// File: tb/fp_to_int_cvt_bench.sv
module fp_to_int_cvt_bench;

  localparam int NV = 32;
  // fields: operand[133:70], ctl {double,wide,signed,chop}[69:66], result[65:2], {inv,inx}[1:0]
  localparam logic [133:0] VEC [NV] = '{
    {64'h000000003F800000, 4'b0010, 64'h0000000000000001, 2'b00}, // R4 exact 1.0
    {64'h0000000040200000, 4'b0010, 64'h0000000000000002, 2'b01}, // R4 2.5 tie -> 2
    {64'h0000000040600000, 4'b0010, 64'h0000000000000004, 2'b01}, // R4 3.5 tie -> 4
    {64'h0000000040200000, 4'b0011, 64'h0000000000000002, 2'b01}, // R5 chop 2.5
    {64'h00000000C0200000, 4'b0010, 64'h00000000FFFFFFFE, 2'b01}, // R4 R11 -2.5
    {64'h00000000C0600000, 4'b0011, 64'h00000000FFFFFFFD, 2'b01}, // R5 chop -3.5
    {64'h00000000BFC00000, 4'b0110, 64'hFFFFFFFFFFFFFFFE, 2'b01}, // R4 -1.5 wide
    {64'h00000000AB98FBA8, 4'b0000, 64'h0000000000000000, 2'b10}, // R6 tiny neg u32
    {64'h00000000AB98FBA8, 4'b0101, 64'h0000000000000000, 2'b10}, // R6 chop u64
    {64'hBD731F7500000000, 4'b1001, 64'h0000000000000000, 2'b10}, // R6 double chop u32
    {64'hBD731F7500000000, 4'b1100, 64'h0000000000000000, 2'b10}, // R6 double u64
    {64'h000000007FC00000, 4'b0010, 64'h00000000FFFFFFFF, 2'b10}, // R7 NaN s32
    {64'h000000007FC00000, 4'b0111, 64'hFFFFFFFFFFFFFFFF, 2'b10}, // R7 NaN s64 chop
    {64'h7FF8000000000000, 4'b1110, 64'hFFFFFFFFFFFFFFFF, 2'b10}, // R7 double NaN
    {64'h000000004F800000, 4'b0000, 64'h00000000FFFFFFFF, 2'b10}, // R8 2^32 u32
    {64'h000000004F000000, 4'b0010, 64'h000000007FFFFFFF, 2'b10}, // R8 2^31 s32
    {64'h00000000CF000000, 4'b0010, 64'h0000000080000000, 2'b00}, // R8 -2^31 exact
    {64'h8000000000000000, 4'b1100, 64'h0000000000000000, 2'b00}, // R10 -0 double u64
    {64'h0000000080000000, 4'b0000, 64'h0000000000000000, 2'b00}, // R10 -0 single u32
    {64'h3FE0000000000000, 4'b1110, 64'h0000000000000000, 2'b01}, // R4 0.5 -> 0
    {64'h3FF8000000000000, 4'b1110, 64'h0000000000000002, 2'b01}, // R4 1.5 -> 2
    {64'h000000007F800000, 4'b0100, 64'hFFFFFFFFFFFFFFFF, 2'b10}, // R8 +inf u64
    {64'h00000000FF800000, 4'b0110, 64'h8000000000000000, 2'b10}, // R8 -inf s64
    {64'h43E0000000000000, 4'b1100, 64'h8000000000000000, 2'b00}, // R8 2^63 u64 fits
    {64'h43E0000000000000, 4'b1110, 64'h7FFFFFFFFFFFFFFF, 2'b10}, // R8 2^63 s64 sat
    {64'h0000000000000001, 4'b0000, 64'h0000000000000000, 2'b01}, // R9 subnormal
    {64'h43EFFFFFFFFFFFFF, 4'b1100, 64'hFFFFFFFFFFFFF800, 2'b00}, // R4 top exponent exact
    {64'h41EFFFFFFFF00000, 4'b1000, 64'h00000000FFFFFFFF, 2'b10}, // R8 round-up overflow
    {64'h41EFFFFFFFF00000, 4'b1001, 64'h00000000FFFFFFFF, 2'b01}, // R5 R9 chop keeps in range
    {64'hDEADBEEF3F800000, 4'b0010, 64'h0000000000000001, 2'b00}, // R3 upper half ignored
    {64'h00000000CF000001, 4'b0010, 64'h0000000080000000, 2'b10}, // R8 below -2^31
    {64'h000000004F7FFFFF, 4'b0000, 64'h00000000FFFFFF00, 2'b00}  // R11 largest < 2^32
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op_bits = '0;
  logic        src_double = 1'b0;
  logic        dst_wide = 1'b0;
  logic        dst_signed = 1'b0;
  logic        chop_mode = 1'b0;
  logic [63:0] int_out;
  logic [5:0]  status_set;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fp_to_int_cvt u_fp_to_int_cvt (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_bits    (op_bits),
    .src_double (src_double),
    .dst_wide   (dst_wide),
    .dst_signed (dst_signed),
    .chop_mode  (chop_mode),
    .int_out    (int_out),
    .status_set (status_set)
  );

  task automatic drive(input logic [63:0] op, input logic [3:0] ctl);
    op_bits    = op;
    src_double = ctl[3];
    dst_wide   = ctl[2];
    dst_signed = ctl[1];
    chop_mode  = ctl[0];
  endtask

  // R12: invalid at bit 1, inexact at bit 5
  function automatic logic [5:0] st(input logic inv, input logic inx);
    return {inx, 3'b000, inv, 1'b0};
  endfunction

  task automatic check(input string req, input logic [63:0] exp_res, input logic [5:0] exp_st);
    total++;
    if (int_out !== exp_res || status_set !== exp_st) begin
      bad++;
      $display("FAIL %s: got result=%h status=%b, expected result=%h status=%b",
               req, int_out, status_set, exp_res, exp_st);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    drive(64'h000000003F800000, 4'b0010);
    repeat (3) @(negedge clk);
    check("R1 reset", 64'h0, 6'b0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][133:70], VEC[i][69:66]);
      @(negedge clk);
      check($sformatf("R12 vector %0d", i), VEC[i][65:2], st(VEC[i][1], VEC[i][0]));
    end
    // R2: new inputs do not show before the next rising edge
    drive(64'h0000000040600000, 4'b0010);
    #1;
    check("R2 holds until edge", VEC[NV-1][65:2], st(VEC[NV-1][1], VEC[NV-1][0]));
    @(negedge clk);
    check("R2 after edge", 64'h4, st(1'b0, 1'b1));
    // R6 with -inf to unsigned narrow, chop
    drive(64'h00000000FF800000, 4'b0001);
    @(negedge clk);
    check("R6 -inf unsigned", 64'h0, st(1'b1, 1'b0));
    // R1: asynchronous reset mid-run
    drive(64'h000000003F800000, 4'b0010);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", 64'h0, 6'b0);
    @(negedge clk);
    finish_run();
  end

endmodule